// File: doc/BRIEF.md
# Floppy Head-Positioning Command Unit

This block is the head-positioning part of a floppy disk controller, seen by a host CPU as a small register window. The host writes a target track, a sector number and a control byte into plain registers. A byte written to the command slot is decoded from its upper nibble into one of five positioning operations: return home, go to a target, step in the remembered direction, step inward or step outward. The unit keeps the physical head position, the last step direction, a host-visible track register and an eight-bit positioning status byte.

Every register access takes one clock cycle on a chip-select, write-enable and 4-bit address port. Read data is combinational from the current state. The stepping arithmetic is bounded to tracks 0 to 79, and the unit never reports a seek error. Reading the status byte returns the flags and then clears all of them except the busy and not-ready bits. Setting bit 2 of the control byte homes the head. The unit has no streaming data path, so every pin is a plain control or status signal.

Top module: `fdc_head_unit`

## Requirements
- R1: After reset, the head position is 0, the remembered direction is inward (+1), and reads at offsets 8, 9, 10, 11 and 12 all return 0.
- R2: Command code 0 (written byte bits 7:4) sets both the head position and the track register (offset 9) to 0. Status becomes 0x06 (INDEX bit 1, TRACK0 bit 2), with HEADLOAD bit 5 (0x20) added when bit 3 of the byte is 1.
- R3: Command code 1 loads the data register (offset 11) into both the head position and the track register, clamped to at most 79. Status becomes INDEX, plus TRACK0 when the result is 0, plus HEADLOAD when byte bit 3 is 1.
- R4: Codes 4–5 move the head by +1 and codes 6–7 move it by −1, with the result held within 0..79. Codes 4–5 set the remembered direction to +1 and codes 6–7 set it to −1.
- R5: Codes 2–3 move the head one track in the remembered direction, with the same 0..79 bound.
- R6: For codes 2–7, the track register takes the new head position only when byte bit 4 is 1. Otherwise it keeps its value.
- R7: After a code 2–7 command, status is 0x02 plus 0x04 when the head is at 0. HEADLOAD is never set by a step, and the seek-error (bit 4) and CRC (bit 3) bits are never set.
- R8: A read of offset 8 returns the status byte. From the next cycle on, the byte keeps only bits 0 and 7, so a second read with no command in between returns 0x00.
- R9: A write to the control register (offset 12) with bit 2 set returns the head to track 0 and leaves the track register unchanged. The written byte reads back from offset 12.
- R10: Command codes 8–15 change neither the head position, the track register nor the status. The sector register (offset 10) reads back what was written, and reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Register access select |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 4 | Register offset within the window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle of the read |
| head_pos | output | 8 | Current physical head track |

## Verification
On every cycle, the checker enforces the 0..79 bound on the head, the absence of seek-error and CRC flags, and the clearing of status after a read. It also checks, one cycle after each event, the head position that follows a home, target or control-reset write. Only the bench scenarios can show the direction memory carried across commands, the effect of the track-register update flag, the exact status codes returned to the host, and the lack of effect of codes 8–15, because each of these depends on an ordered sequence of accesses.

// File: rtl/fdc_hp_pkg.sv
package fdc_hp_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFS_STATUS  = 4'd8;
  localparam logic [ADDR_W-1:0] OFS_TRACK   = 4'd9;
  localparam logic [ADDR_W-1:0] OFS_SECTOR  = 4'd10;
  localparam logic [ADDR_W-1:0] OFS_DATA    = 4'd11;
  localparam logic [ADDR_W-1:0] OFS_CONTROL = 4'd12;

  // status bit positions, decoded by host software
  localparam int ST_BUSY  = 0;
  localparam int ST_INDEX = 1;
  localparam int ST_ZERO  = 2;
  localparam int ST_HEAD  = 5;
  localparam int ST_NRDY  = 7;

  localparam logic [DATA_W-1:0] ST_KEEP_MASK =
    (DATA_W'(1) << ST_BUSY) | (DATA_W'(1) << ST_NRDY);

  localparam int CTL_HOME_BIT = 2;
  localparam int CMD_HL_BIT   = 3;
  localparam int CMD_UPD_BIT  = 4;

  typedef enum logic [2:0] {
    OP_NONE, OP_HOME, OP_GOTO, OP_STEP, OP_INWARD, OP_OUTWARD
  } hp_op_e;

  function automatic hp_op_e decode_op(input logic [3:0] code);
    case (code)
      4'd0:        decode_op = OP_HOME;
      4'd1:        decode_op = OP_GOTO;
      4'd2, 4'd3:  decode_op = OP_STEP;
      4'd4, 4'd5:  decode_op = OP_INWARD;
      4'd6, 4'd7:  decode_op = OP_OUTWARD;
      default:     decode_op = OP_NONE;
    endcase
  endfunction
endpackage

// File: rtl/fdc_hp_stepper.sv
module fdc_hp_stepper
  import fdc_hp_pkg::*;
#(
  parameter int W = 8,
  parameter int MAX_TRACK = 79
) (
  input  logic         clk,
  input  logic         rst_n,
  input  hp_op_e       op,
  input  logic [W-1:0] target,
  input  logic         home,
  output logic [W-1:0] pos,
  output logic [W-1:0] nxt
);
  localparam logic [W-1:0] LIMIT = W'(MAX_TRACK);

  logic         dir_in;
  logic [W-1:0] up, down;

  assign up   = (pos >= LIMIT) ? LIMIT : pos + W'(1);
  assign down = (pos == '0) ? '0 : pos - W'(1);

  always_comb begin
    case (op)
      OP_HOME:    nxt = '0;
      OP_GOTO:    nxt = (target > LIMIT) ? LIMIT : target;
      OP_STEP:    nxt = dir_in ? up : down;
      OP_INWARD:  nxt = up;
      OP_OUTWARD: nxt = down;
      default:    nxt = pos;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos    <= '0;
      dir_in <= 1'b1;
    end else if (op != OP_NONE) begin
      pos <= nxt;
      if (op == OP_INWARD)  dir_in <= 1'b1;
      if (op == OP_OUTWARD) dir_in <= 1'b0;
    end else if (home) begin
      pos <= '0;
    end
  end
endmodule

// File: rtl/fdc_hp_status.sv
module fdc_hp_status
  import fdc_hp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         at_zero,
  input  logic         head_set,
  input  logic         rd_clear,
  output logic [W-1:0] flags
);
  logic [W-1:0] fresh;

  always_comb begin
    fresh = '0;
    fresh[ST_INDEX] = 1'b1;
    fresh[ST_ZERO]  = at_zero;
    fresh[ST_HEAD]  = head_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         flags <= '0;
    else if (load)      flags <= fresh;
    else if (rd_clear)  flags <= flags & W'(ST_KEEP_MASK);
  end
endmodule

// File: rtl/fdc_hp_regs.sv
module fdc_hp_regs
  import fdc_hp_pkg::*;
#(
  parameter int W = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  input  logic          trk_load,
  input  logic [W-1:0]  trk_val,
  output logic [W-1:0]  track_q,
  output logic [W-1:0]  sector_q,
  output logic [W-1:0]  data_q,
  output logic [W-1:0]  ctl_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      track_q  <= '0;
      sector_q <= '0;
      data_q   <= '0;
      ctl_q    <= '0;
    end else begin
      if (trk_load)                         track_q  <= trk_val;
      else if (wr && addr == OFS_TRACK)     track_q  <= wdata;
      if (wr && addr == OFS_SECTOR)         sector_q <= wdata;
      if (wr && addr == OFS_DATA)           data_q   <= wdata;
      if (wr && addr == OFS_CONTROL)        ctl_q    <= wdata;
    end
  end
endmodule

// File: rtl/fdc_head_unit.sv
module fdc_head_unit
  import fdc_hp_pkg::*;
#(
  parameter int MAX_TRACK = 79
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] head_pos
);
  logic              wr, rd, cmd_wr, applied, trk_load, head_set, home;
  hp_op_e            op;
  logic [DATA_W-1:0] nxt, track_q, sector_q, data_q, ctl_q, status_q;

  assign wr      = cs && we;
  assign rd      = cs && !we;
  assign cmd_wr  = wr && addr == OFS_STATUS;
  assign op      = cmd_wr ? decode_op(wdata[7:4]) : OP_NONE;
  assign applied = op != OP_NONE;
  assign home    = wr && addr == OFS_CONTROL && wdata[CTL_HOME_BIT];

  assign head_set = wdata[CMD_HL_BIT] && (op == OP_HOME || op == OP_GOTO);
  assign trk_load = applied &&
                    (op == OP_HOME || op == OP_GOTO || wdata[CMD_UPD_BIT]);

  fdc_hp_stepper #(.W(DATA_W), .MAX_TRACK(MAX_TRACK)) u_step (
    .clk(clk), .rst_n(rst_n), .op(op), .target(data_q), .home(home),
    .pos(head_pos), .nxt(nxt)
  );

  fdc_hp_status #(.W(DATA_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .load(applied), .at_zero(nxt == '0),
    .head_set(head_set), .rd_clear(rd && addr == OFS_STATUS),
    .flags(status_q)
  );

  fdc_hp_regs #(.W(DATA_W), .AW(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(wr), .addr(addr), .wdata(wdata),
    .trk_load(trk_load), .trk_val(nxt),
    .track_q(track_q), .sector_q(sector_q), .data_q(data_q), .ctl_q(ctl_q)
  );

  always_comb begin
    case (addr)
      OFS_STATUS:  rdata = status_q;
      OFS_TRACK:   rdata = track_q;
      OFS_SECTOR:  rdata = sector_q;
      OFS_DATA:    rdata = data_q;
      OFS_CONTROL: rdata = ctl_q;
      default:     rdata = '0;
    endcase
  end
endmodule

// File: rtl/fdc_head_unit_chk.sv
module fdc_head_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs,
  input logic       we,
  input logic [3:0] addr,
  input logic [7:0] wdata,
  input logic [7:0] head_pos,
  input logic [7:0] track_q,
  input logic [7:0] data_q,
  input logic [7:0] status_q
);
  logic cmd_wr;
  assign cmd_wr = cs && we && addr == 4'd8;

  // R4
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    head_pos <= 8'd79);

  // R2
  home_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && wdata[7:4] == 4'd0 |=> head_pos == 8'd0 && track_q == 8'd0);

  // R3
  goto_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && wdata[7:4] == 4'd1 |=>
      head_pos == (($past(data_q) > 8'd79) ? 8'd79 : $past(data_q)));

  // R7
  no_seek_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[4] == 1'b0 && status_q[3] == 1'b0);

  // R8
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs && !we && addr == 4'd8 |=> (status_q & 8'h7E) == 8'h00);

  // R9
  ctl_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs && we && addr == 4'd12 && wdata[2] |=>
      head_pos == 8'd0 && $stable(track_q));
endmodule

bind fdc_head_unit fdc_head_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
  .head_pos(head_pos), .track_q(track_q), .data_q(data_q),
  .status_q(status_q)
);

// File: tb/fdc_head_unit_tb.sv
`timescale 1ns/100ps
module fdc_head_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, we = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, head_pos;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fdc_head_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .head_pos(head_pos)
  );

  task automatic chk(input string req, input string what,
                     input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    cs = 1'b1; we = 1'b0; addr = a;
    #1 v = rdata;
    @(negedge clk);
    cs = 1'b0;
  endtask

  task automatic expect_reg(input string req, input logic [3:0] a,
                            input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, $sformatf("reg %0d", a), v, exp);
  endtask

  task automatic t_reset;
    chk("R1", "head_pos", head_pos, 0);
    for (int a = 8; a <= 12; a++) expect_reg("R1", 4'(a), 8'h00);
  endtask

  task automatic t_direction;
    wr(4'd8, 8'h30);                    // plain step, update; dir +1 after reset
    chk("R5", "head after first step", head_pos, 1);
    expect_reg("R6", 4'd9, 8'd1);
    expect_reg("R7", 4'd8, 8'h02);
    wr(4'd8, 8'h70);                    // step out to 0
    chk("R4", "head after step out", head_pos, 0);
    expect_reg("R7", 4'd8, 8'h06);
    wr(4'd8, 8'h70);                    // clamp at 0
    chk("R4", "clamp low", head_pos, 0);
    expect_reg("R7", 4'd8, 8'h06);
    wr(4'd8, 8'h30);                    // remembered direction is -1
    chk("R5", "step after step out", head_pos, 0);
  endtask

  task automatic t_goto_home;
    wr(4'd11, 8'd20);
    wr(4'd8, 8'h10);
    chk("R3", "head after goto", head_pos, 20);
    expect_reg("R3", 4'd9, 8'd20);
    expect_reg("R3", 4'd8, 8'h02);
    wr(4'd8, 8'h08);                    // home with head-load
    chk("R2", "head after home", head_pos, 0);
    expect_reg("R2", 4'd9, 8'd0);
    expect_reg("R2", 4'd8, 8'h26);
    expect_reg("R8", 4'd8, 8'h00);
  endtask

  task automatic t_goto_clamp;
    wr(4'd11, 8'd200);
    wr(4'd8, 8'h18);
    chk("R3", "goto clamp", head_pos, 79);
    expect_reg("R3", 4'd9, 8'd79);
    expect_reg("R3", 4'd8, 8'h22);
    wr(4'd11, 8'd0);
    wr(4'd8, 8'h10);
    expect_reg("R3", 4'd8, 8'h06);
  endtask

  task automatic t_inward_clamp;
    wr(4'd11, 8'd78);
    wr(4'd8, 8'h10);
    wr(4'd8, 8'h50);
    chk("R4", "step in", head_pos, 79);
    wr(4'd8, 8'h58);                    // bit 3 set: no head-load on a step
    chk("R4", "clamp high", head_pos, 79);
    expect_reg("R7", 4'd8, 8'h02);
    expect_reg("R6", 4'd9, 8'd79);
    wr(4'd8, 8'h60);                    // step out, no update
    chk("R6", "head after no-update step", head_pos, 78);
    expect_reg("R6", 4'd9, 8'd79);
  endtask

  task automatic t_control;
    wr(4'd12, 8'h04);
    chk("R9", "head after control home", head_pos, 0);
    expect_reg("R9", 4'd9, 8'd79);
    expect_reg("R9", 4'd12, 8'h04);
    wr(4'd8, 8'h60);                    // at 0 now: clamps, proves home
    chk("R9", "step out after control home", head_pos, 0);
  endtask

  task automatic t_ignored;
    logic [7:0] v;
    wr(4'd11, 8'd33);
    wr(4'd8, 8'h10);
    rd(4'd8, v);
    wr(4'd8, 8'h90);
    wr(4'd8, 8'hF8);
    chk("R10", "head after codes 8-15", head_pos, 33);
    expect_reg("R10", 4'd9, 8'd33);
    expect_reg("R10", 4'd8, 8'h00);
    wr(4'd10, 8'h5A);
    expect_reg("R10", 4'd10, 8'h5A);
    expect_reg("R10", 4'd3, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_direction();
    t_goto_home();
    t_goto_clamp();
    t_inward_clamp();
    t_control();
    t_ignored();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule